// File: doc/BRIEF.md
# Vectored Interrupt Controller with Spurious Detection

This block collects a set of interrupt inputs and presents them to a small processor core as two active-low request lines: a normal request (`irq_n`) and a fast request (`fiq_n`). Every input has a mode register that selects its trigger type and a 3-bit priority, and a vector register that holds its handler address. Input 0 is the fast input. It drives only `fiq_n` and never competes in priority selection. Inputs 1 and up share `irq_n`. Input 1 is normally used as a software interrupt: it is set to an edge trigger and raised by a register write.

The core reads the normal vector register to get the handler address of the winning input. That read acknowledges the input and holds `irq_n` high until an end-of-service write. The request may vanish between assertion and the vector read, for example when a level input drops or software masks the input. In that case the read returns a programmable spurious vector. Both request lines then stay blocked until software writes end-of-service. The fast vector register behaves the same way for input 0.

The register interface is a single-cycle word bus. A write takes effect at the clock edge where `bus_wr` is high. A read is captured into `bus_rdata` at the edge where `bus_rd` is high, and its side effects take effect at that same edge.

Top module: `vic_ctrl`

## Requirements
- R1: Synchronous active-high reset sets `irq_n` and `fiq_n` high, the mask to 0, every edge pending latch to 0, every mode to high-level with priority 0, and the acknowledge state to idle.
- R2: A write to the enable command (word 0x24) sets every mask bit that is 1 in the data. A write to the disable command (0x25) clears every mask bit that is 1 in the data. The mask register (0x23) reads back the result in bits [NSRC-1:0].
- R3: The mode register of input i (word i) holds the trigger in bits [5:4]: 0 high level, 1 low level, 2 rising edge, 3 falling edge. A level input is pending while its input is at the active level. An edge input latches pending on the selected edge and keeps it. The pending register (0x22) shows bit i per input. Inputs are sampled by one register stage.
- R4: Among inputs 1 and up that are pending and unmasked, the one with the highest priority (mode bits [2:0]) wins, and a tie goes to the lowest input number. A read of the normal vector register (0x20) returns the winner's vector register (word 0x10+i).
- R5: A normal vector read that finds a winner, made while idle, clears the winner's pending latch if it is edge-triggered. `irq_n` is then held high until a write to end-of-service (0x28).
- R6: Only input 0 can drive `fiq_n` low, and only while it is pending and unmasked. It never wins the normal arbitration. A read of the fast vector register (0x21) while it is pending returns vector register 0x10 and clears its edge latch.
- R7: The set command (0x26) and clear command (0x27) set or clear the pending latch of each input whose data bit is 1, including input 0. Both commands have no effect on inputs configured for a level trigger.
- R8: Input 1, configured rising-edge and unmasked, raises `irq_n` after a set command with bit 1, and its vector is returned on the normal vector read.
- R9: A normal vector read made while idle with no unmasked pending input 1 and up returns the spurious vector register (0x29). A fast vector read with input 0 not pending and unmasked also returns the spurious vector.
- R10: After a spurious read made while idle, `irq_n` and `fiq_n` both stay high whatever is pending until an end-of-service write, which returns the controller to idle.
- R11: If a raised request disappears before the vector read, either because a level input drops or because the input is disabled through the disable command, the read returns the spurious vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Interrupt inputs, bit 0 is the fast input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| irq_n | output | 1 | Normal request to the core, active low |
| fiq_n | output | 1 | Fast request to the core, active low |

## Verification
Trigger handling is tried with all four trigger codes on separate inputs driven in one pattern. Input pulses show that edge latches hold while level inputs follow the pin, and set and clear commands show that only edge inputs respond. Arbitration is tried with four simultaneously pending inputs. Two of them share a priority, so the acknowledge order separates priority from input number. Spurious handling is tried three ways: a read with nothing pending, a level input that drops before the read, and an input disabled before the read. In each case, pending activity during the blocked state shows that both lines stay high until end-of-service.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int PRIO_W = 3;

    typedef enum logic [1:0] {
        TRG_HIGH = 2'd0,
        TRG_LOW  = 2'd1,
        TRG_RISE = 2'd2,
        TRG_FALL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SERVICE = 2'd1,
        ST_SPUR    = 2'd2
    } ack_st_e;

    localparam logic [5:0] A_VEC_BASE = 6'h10;
    localparam logic [5:0] A_IVEC     = 6'h20;
    localparam logic [5:0] A_FVEC     = 6'h21;
    localparam logic [5:0] A_PEND     = 6'h22;
    localparam logic [5:0] A_MASK     = 6'h23;
    localparam logic [5:0] A_ENA      = 6'h24;
    localparam logic [5:0] A_DIS      = 6'h25;
    localparam logic [5:0] A_SET      = 6'h26;
    localparam logic [5:0] A_CLR      = 6'h27;
    localparam logic [5:0] A_EOI      = 6'h28;
    localparam logic [5:0] A_SPUR     = 6'h29;

    function automatic logic trig_is_edge(trig_e t);
        return t == TRG_RISE || t == TRG_FALL;
    endfunction

    function automatic logic trig_level_active(trig_e t, logic s);
        return (t == TRG_HIGH) ? s : ~s;
    endfunction

endpackage

// File: rtl/vic_trigger.sv
module vic_trigger
    import vic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src_in,
    input  trig_e trig,
    input  logic  set_cmd,
    input  logic  clr_cmd,
    input  logic  ack_clr,
    output logic  pend
);
    logic src_q, src_d, latch_q, edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= 1'b0;
            src_d <= 1'b0;
        end else begin
            src_q <= src_in;
            src_d <= src_q;
        end
    end

    always_comb begin
        if (trig == TRG_RISE) edge_hit = src_q & ~src_d;
        else                  edge_hit = ~src_q & src_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                     latch_q <= 1'b0;
        else if (!trig_is_edge(trig)) latch_q <= 1'b0;
        else latch_q <= (latch_q | edge_hit | set_cmd) & ~clr_cmd & ~ack_clr;
    end

    assign pend = trig_is_edge(trig) ? latch_q : trig_level_active(trig, src_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NSRC  = 8,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]   req,
    input  logic [PRIO_W-1:0] prio [NSRC],
    output logic              any,
    output logic [IDX_W-1:0]  best
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        any    = 1'b0;
        best   = '0;
        best_p = '0;
        for (int i = 1; i < NSRC; i++) begin
            if (req[i] && (!any || prio[i] > best_p)) begin
                any    = 1'b1;
                best_p = prio[i];
                best   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm
    import vic_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    irq_take,
    input  logic    spur_take,
    input  logic    eoi,
    output ack_st_e st
);
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else if (eoi) st <= ST_IDLE;
        else if (st == ST_IDLE) begin
            if (irq_take)       st <= ST_SERVICE;
            else if (spur_take) st <= ST_SPUR;
        end
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int DW   = 32,
    parameter int AW   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_n,
    output logic            fiq_n
);
    localparam int IDX_W = $clog2(NSRC);

    trig_e             trig_q [NSRC];
    logic [PRIO_W-1:0] prio_q [NSRC];
    logic [DW-1:0]     vec_q  [NSRC];
    logic [DW-1:0]     spur_q;
    logic [NSRC-1:0]   mask_q, pend, set_v, clr_v, ack_v;
    logic              any_irq, fiq_avail, irq_rd, fiq_rd, eoi_wr;
    logic              irq_take, spur_take;
    logic [IDX_W-1:0]  best;
    ack_st_e           st;

    wire [5:0] a6      = 6'(bus_addr);
    wire       in_rng  = {1'b0, a6[3:0]} < 5'(NSRC);
    wire       mode_wr = bus_wr && a6[5:4] == 2'b00 && in_rng;
    wire       vec_wr  = bus_wr && a6[5:4] == 2'b01 && in_rng;

    assign irq_rd = bus_rd && a6 == A_IVEC;
    assign fiq_rd = bus_rd && a6 == A_FVEC;
    assign eoi_wr = bus_wr && a6 == A_EOI;
    assign set_v  = (bus_wr && a6 == A_SET) ? bus_wdata[NSRC-1:0] : '0;
    assign clr_v  = (bus_wr && a6 == A_CLR) ? bus_wdata[NSRC-1:0] : '0;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) begin
                    trig_q[g] <= TRG_HIGH;
                    prio_q[g] <= '0;
                    vec_q[g]  <= '0;
                end else begin
                    if (mode_wr && a6[3:0] == 4'(g)) begin
                        trig_q[g] <= trig_e'(bus_wdata[5:4]);
                        prio_q[g] <= bus_wdata[PRIO_W-1:0];
                    end
                    if (vec_wr && a6[3:0] == 4'(g)) vec_q[g] <= bus_wdata;
                end
            end

            vic_trigger u_trg (
                .clk     (clk),
                .rst     (rst),
                .src_in  (src_in[g]),
                .trig    (trig_q[g]),
                .set_cmd (set_v[g]),
                .clr_cmd (clr_v[g]),
                .ack_clr (ack_v[g]),
                .pend    (pend[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            spur_q <= '0;
        end else begin
            if (bus_wr && a6 == A_ENA) mask_q <= mask_q | bus_wdata[NSRC-1:0];
            if (bus_wr && a6 == A_DIS) mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
            if (bus_wr && a6 == A_SPUR) spur_q <= bus_wdata;
        end
    end

    vic_arbiter #(.NSRC(NSRC)) u_arb (
        .req  (pend & mask_q & ~NSRC'(1)),
        .prio (prio_q),
        .any  (any_irq),
        .best (best)
    );

    assign fiq_avail = pend[0] & mask_q[0];
    assign irq_take  = irq_rd && st == ST_IDLE && any_irq;
    assign spur_take = (irq_rd && !any_irq) || (fiq_rd && !fiq_avail);

    always_comb begin
        ack_v = '0;
        if (irq_take)             ack_v[best] = 1'b1;
        if (fiq_rd && fiq_avail)  ack_v[0]    = 1'b1;
    end

    vic_ack_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .irq_take  (irq_take),
        .spur_take (spur_take),
        .eoi       (eoi_wr),
        .st        (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            irq_n     <= 1'b1;
            fiq_n     <= 1'b1;
        end else begin
            irq_n <= !(st == ST_IDLE && any_irq);
            fiq_n <= !(st != ST_SPUR && fiq_avail);
            if (bus_rd) begin
                if (a6[5:4] == 2'b00 && in_rng)
                    bus_rdata <= DW'({trig_q[a6[IDX_W-1:0]], 1'b0, prio_q[a6[IDX_W-1:0]]});
                else if (a6[5:4] == 2'b01 && in_rng)
                    bus_rdata <= vec_q[a6[IDX_W-1:0]];
                else begin
                    case (a6)
                        A_IVEC:  bus_rdata <= irq_take ? vec_q[best] : spur_q;
                        A_FVEC:  bus_rdata <= fiq_avail ? vec_q[0] : spur_q;
                        A_PEND:  bus_rdata <= DW'(pend);
                        A_MASK:  bus_rdata <= DW'(mask_q);
                        A_SPUR:  bus_rdata <= spur_q;
                        default: bus_rdata <= '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int AW   = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_n,
    input logic            fiq_n,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [NSRC-1:0] mask,
    input ack_st_e         st
);
    p_reset_lines_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_n && fiq_n));

    p_irq_masked_r2: assert property (@(posedge clk) disable iff (rst)
        (mask[NSRC-1:1] == '0) |=> irq_n);

    p_service_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SERVICE) |=> irq_n);

    p_fiq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        !mask[0] |=> fiq_n);

    p_spur_block_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SPUR) |=> (irq_n && fiq_n));

    p_eoi_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 6'(bus_addr) == A_EOI) |=> (st == ST_IDLE));
endmodule

bind vic_ctrl vic_ctrl_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_n    (irq_n),
    .fiq_n    (fiq_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .mask     (mask_q),
    .st       (st)
);

// File: tb/tb_vic_ctrl.sv
`timescale 1ns/1ps
module tb_vic_ctrl;
    localparam int NSRC = 8;
    localparam logic [31:0] SPV = 32'hDEAD_0000;

    logic            clk = 0;
    logic            rst = 1;
    logic [NSRC-1:0] src_in = '0;
    logic            bus_wr = 0, bus_rd = 0;
    logic [5:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0, bus_rdata;
    logic            irq_n, fiq_n;
    int              n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    vic_ctrl #(.NSRC(NSRC)) dut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .fiq_n(fiq_n)
    );

    function automatic logic [31:0] vec_of(int i);
        return 32'hA000_0000 + 32'(i * 16);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic eoi();
        wr(6'h28, 0);
        cyc(3);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_n", 32'(irq_n), 1);
        chk("R1 fiq_n", 32'(fiq_n), 1);
        rd(6'h23, d); chk("R1 mask", d, 0);
        rd(6'h22, d); chk("R1 pending", d, 0);
        rd(6'h03, d); chk("R1 mode", d, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(6'h24, 32'hF6);
        rd(6'h23, d); chk("R2 enable", d, 32'hF6);
        wr(6'h25, 32'h12);
        rd(6'h23, d); chk("R2 disable", d, 32'hE4);
        wr(6'h25, 32'hFF);
        rd(6'h23, d); chk("R2 all off", d, 0);
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        src_in[3] = 1; src_in[5] = 1;
        cyc(3);
        wr(6'h02, 32'h00); wr(6'h03, 32'h10); wr(6'h04, 32'h20); wr(6'h05, 32'h30);
        cyc(2);
        rd(6'h22, d); chk("R3 idle pattern", d, 0);
        src_in[2] = 1; src_in[3] = 0; src_in[4] = 1; src_in[5] = 0;
        cyc(2);
        src_in[4] = 0;
        cyc(3);
        rd(6'h22, d); chk("R3 all active", d, 32'h3C);
        src_in[2] = 0; src_in[3] = 1;
        cyc(3);
        rd(6'h22, d); chk("R3 edges held", d, 32'h30);
        wr(6'h27, 32'h3C);
        rd(6'h22, d); chk("R7 clear edges", d, 0);
        chk("R3 masked irq_n", 32'(irq_n), 1);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        wr(6'h26, 32'h3C);
        rd(6'h22, d); chk("R7 set edge only", d, 32'h30);
        wr(6'h27, 32'h30);
        rd(6'h22, d); chk("R7 clear", d, 0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(6'h01, 32'h22); wr(6'h02, 32'h25); wr(6'h03, 32'h25); wr(6'h04, 32'h21);
        wr(6'h24, 32'hFE);
        wr(6'h26, 32'h1E);
        cyc(2);
        chk("R4 irq asserted", 32'(irq_n), 0);
        rd(6'h20, d); chk("R4 tie lowest", d, vec_of(2));
        cyc(2);
        chk("R5 held high", 32'(irq_n), 1);
        rd(6'h22, d); chk("R5 edge cleared", d, 32'h1A);
        eoi();
        chk("R5 reasserted", 32'(irq_n), 0);
        rd(6'h20, d); chk("R4 second", d, vec_of(3));
        eoi();
        rd(6'h20, d); chk("R4 third", d, vec_of(1));
        eoi();
        rd(6'h20, d); chk("R4 fourth", d, vec_of(4));
        eoi();
        chk("R4 drained", 32'(irq_n), 1);
    endtask

    task automatic t_swi();
        logic [31:0] d;
        wr(6'h26, 32'h02);
        cyc(2);
        chk("R8 swi irq", 32'(irq_n), 0);
        rd(6'h20, d); chk("R8 swi vector", d, vec_of(1));
        eoi();
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        wr(6'h25, 32'hFF); wr(6'h24, 32'h01);
        wr(6'h00, 32'h20);
        src_in[0] = 1; cyc(2); src_in[0] = 0; cyc(3);
        chk("R6 fiq low", 32'(fiq_n), 0);
        chk("R6 irq untouched", 32'(irq_n), 1);
        rd(6'h21, d); chk("R6 fiq vector", d, vec_of(0));
        cyc(2);
        chk("R6 edge acked", 32'(fiq_n), 1);
        wr(6'h24, 32'hFE);
        wr(6'h26, 32'h01);
        cyc(2);
        chk("R7 set fast", 32'(fiq_n), 0);
        chk("R6 no irq from src0", 32'(irq_n), 1);
        wr(6'h27, 32'h01);
        cyc(2);
        chk("R7 clear fast", 32'(fiq_n), 1);
        wr(6'h00, 32'h10);
        cyc(3);
        chk("R6 low level", 32'(fiq_n), 0);
        rd(6'h21, d); chk("R6 level vector", d, vec_of(0));
        src_in[0] = 1; cyc(3);
        chk("R6 level gone", 32'(fiq_n), 1);
        wr(6'h25, 32'h01);
    endtask

    task automatic t_spur_empty();
        logic [31:0] d;
        rd(6'h20, d); chk("R9 irq spurious", d, SPV);
        wr(6'h26, 32'h02);
        cyc(3);
        chk("R10 irq blocked", 32'(irq_n), 1);
        eoi();
        chk("R10 unblocked", 32'(irq_n), 0);
        rd(6'h20, d); chk("R10 after eoi", d, vec_of(1));
        eoi();
        rd(6'h21, d); chk("R9 fiq spurious", d, SPV);
        wr(6'h24, 32'h01); wr(6'h00, 32'h20); wr(6'h26, 32'h01);
        cyc(3);
        chk("R10 fiq blocked", 32'(fiq_n), 1);
        eoi();
        chk("R10 fiq unblocked", 32'(fiq_n), 0);
        wr(6'h27, 32'h01); wr(6'h25, 32'h01);
    endtask

    task automatic t_spur_level();
        logic [31:0] d;
        wr(6'h06, 32'h04);
        src_in[6] = 1; cyc(3);
        chk("R11 level raised", 32'(irq_n), 0);
        src_in[6] = 0; cyc(2);
        rd(6'h20, d); chk("R11 level dropped", d, SPV);
        eoi();
        src_in[6] = 1; cyc(3);
        chk("R11 raised again", 32'(irq_n), 0);
        wr(6'h25, 32'h40);
        rd(6'h20, d); chk("R11 disabled", d, SPV);
        eoi();
        src_in[6] = 0;
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 0;
        cyc(2);
        t_reset();
        for (int i = 0; i < NSRC; i++) wr(6'h10 + 6'(i), vec_of(i));
        wr(6'h29, SPV);
        t_mask();
        t_trigger();
        t_setclr();
        t_prio();
        t_swi();
        t_fiq();
        t_spur_empty();
        t_spur_level();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule